// File: doc/BRIEF.md
# Display Line Timing Generator with Line-Match Interrupt

This block paces a raster display. A horizontal tick counter splits every line into an active portion followed by a blanking portion. By default these are 3072 and 1188 ticks, which is 256 and 99 slots of 12 ticks each. A line counter steps through a frame of 263 lines, of which the first 192 are visible. The block keeps one 16-bit status word. The word holds three live flags: vertical blank, horizontal blank and line match. It also holds the software-written interrupt enables and a 9-bit compare value.

Each cycle the block may emit single-cycle interrupt requests for vertical blank, horizontal blank and line match. It also drives two single-cycle strobes that DMA engines use as triggers. One strobe fires at the start of horizontal blank on visible lines only. The other fires on entry to vertical blank. Software reads the status word at any time, and reads the current line number on its own port. A write updates the enable and compare fields. The flag bits cannot be written.

Top module: `disp_timing`

## Requirements
- R1: While reset is held and in the first cycle after it, the status word, the line number and all five pulse outputs are zero.
- R2: Each line lasts ACTIVE_TICKS + BLANK_TICKS clock cycles. At the end of each line the line number increments by one, and it goes from LINES-1 back to 0.
- R3: Status bit 1 (horizontal blank) rises once ACTIVE_TICKS cycles of a line have passed. It falls in the same cycle that the line number advances.
- R4: Status bit 0 (vertical blank) rises in the cycle the line number becomes VIS_LINES. It falls in the cycle the line number wraps to 0.
- R5: The compare value is 9 bits: status bit 7 is its bit 8 and status bits 15:8 are its bits 7:0. Each time the line number advances, status bit 2 is set if the new line number equals the compare value and cleared otherwise. It does not change at any other time.
- R6: The match interrupt pulses for one cycle, in the cycle that status bit 2 goes from 0 to 1, when status bit 5 was set before that cycle. If the flag is already set and stays set, there is no pulse.
- R7: The horizontal DMA strobe pulses in the same cycle that status bit 1 rises, but only on lines below VIS_LINES. The vertical DMA strobe pulses in the same cycle that status bit 0 rises.
- R8: The vertical blank interrupt pulses when status bit 0 rises, if status bit 3 was set. The horizontal blank interrupt pulses when status bit 1 rises, if status bit 4 was set. Each pulse lasts one cycle.
- R9: A write stores data bits 15:7 and 5:3, and they read back from the next cycle on. Bits 2:0 keep their flag values and bit 6 always reads 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 16 | Write data for the status word |
| stat_o | output | 16 | Status word: flags, enables, compare value |
| line_o | output | LINE_W | Current line number |
| irq_vblank_o | output | 1 | Vertical blank interrupt pulse |
| irq_hblank_o | output | 1 | Horizontal blank interrupt pulse |
| irq_match_o | output | 1 | Line-match interrupt pulse |
| hblank_dma_o | output | 1 | Horizontal blank DMA trigger, visible lines only |
| vblank_dma_o | output | 1 | Vertical blank DMA trigger |

## Verification
The tick counter is hidden, and its errors show up one line later: the line number steps at the wrong time, and the horizontal blank flag rises in the wrong tick, within one line period. An error in the line counter shows on line_o, and it also moves the vertical blank flag and the DMA strobes within a frame. A stale or wrong compare value, or wrong match-flag history, shows up when the match flag and its interrupt appear on the wrong line. Extra or missing pulses appear in the very next cycle. The bench therefore compares every output in every cycle against a model of the requirements. It runs the block with short lines and frames, so that many line wraps, frame wraps and rewrites of the compare value happen within the run.

// File: rtl/disp_timing_pkg.sv
package disp_timing_pkg;
  localparam int VB_BIT  = 0;
  localparam int HB_BIT  = 1;
  localparam int LM_BIT  = 2;
  localparam int VB_IE   = 3;
  localparam int HB_IE   = 4;
  localparam int LM_IE   = 5;
  localparam int CMP_MSB = 7;
  localparam logic [15:0] WR_MASK = 16'hFFB8;

  // pulse vector order
  localparam int P_VIRQ = 0;
  localparam int P_HIRQ = 1;
  localparam int P_MIRQ = 2;
  localparam int P_HDMA = 3;
  localparam int P_VDMA = 4;
  localparam int NUM_P  = 5;
endpackage

// File: rtl/dt_hcount.sv
module dt_hcount #(
  parameter int ACTIVE_TICKS = 3072,
  parameter int BLANK_TICKS  = 1188
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hb_start_o,
  output logic line_end_o
);
  localparam int TOTAL = ACTIVE_TICKS + BLANK_TICKS;
  localparam int HW    = $clog2(TOTAL);

  logic [HW-1:0] h_q;

  assign hb_start_o = (h_q == HW'(ACTIVE_TICKS - 1));
  assign line_end_o = (h_q == HW'(TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         h_q <= '0;
    else if (line_end_o) h_q <= '0;
    else                 h_q <= h_q + 1'b1;
  end
endmodule

// File: rtl/dt_vcount.sv
module dt_vcount #(
  parameter int LINES  = 263,
  parameter int LINE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LINE_W-1:0] line_o,
  output logic [LINE_W-1:0] line_nxt_o
);
  logic [LINE_W-1:0] line_q;

  assign line_nxt_o = (line_q == LINE_W'(LINES - 1)) ? '0 : line_q + 1'b1;
  assign line_o     = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= '0;
    else if (adv_i) line_q <= line_nxt_o;
  end
endmodule

// File: rtl/dt_status.sv
module dt_status
  import disp_timing_pkg::*;
#(
  parameter int VIS_LINES = 192,
  parameter int LINE_W    = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  input  logic              hb_start_i,
  input  logic              line_end_i,
  input  logic [LINE_W-1:0] line_nxt_i,
  output logic [15:0]       stat_o,
  output logic              vb_enter_o,
  output logic              lm_rise_o,
  output logic              en_vb_o,
  output logic              en_hb_o,
  output logic              en_lm_o
);
  logic [15:0] ctrl_q;
  logic        hb_q, vb_q, lm_q;
  logic [8:0]  cmp_val;
  logic        lm_nxt;

  assign cmp_val    = {ctrl_q[CMP_MSB], ctrl_q[15:8]};
  assign lm_nxt     = (32'(line_nxt_i) == 32'(cmp_val));
  assign vb_enter_o = line_end_i && (line_nxt_i == LINE_W'(VIS_LINES));
  assign lm_rise_o  = line_end_i && lm_nxt && !lm_q;
  assign en_vb_o    = ctrl_q[VB_IE];
  assign en_hb_o    = ctrl_q[HB_IE];
  assign en_lm_o    = ctrl_q[LM_IE];

  always_comb begin
    stat_o         = ctrl_q;
    stat_o[VB_BIT] = vb_q;
    stat_o[HB_BIT] = hb_q;
    stat_o[LM_BIT] = lm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i & WR_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hb_q <= 1'b0;
      vb_q <= 1'b0;
      lm_q <= 1'b0;
    end else begin
      if (hb_start_i) hb_q <= 1'b1;
      if (line_end_i) begin
        hb_q <= 1'b0;
        lm_q <= lm_nxt;
        if (line_nxt_i == LINE_W'(VIS_LINES)) vb_q <= 1'b1;
        else if (line_nxt_i == '0)            vb_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dt_irq.sv
module dt_irq
  import disp_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hb_start_i,
  input  logic             vb_enter_i,
  input  logic             lm_rise_i,
  input  logic             line_vis_i,
  input  logic             en_vb_i,
  input  logic             en_hb_i,
  input  logic             en_lm_i,
  output logic [NUM_P-1:0] pulse_o
);
  logic [NUM_P-1:0] ev;

  always_comb begin
    ev         = '0;
    ev[P_VIRQ] = vb_enter_i && en_vb_i;
    ev[P_HIRQ] = hb_start_i && en_hb_i;
    ev[P_MIRQ] = lm_rise_i  && en_lm_i;
    ev[P_HDMA] = hb_start_i && line_vis_i;
    ev[P_VDMA] = vb_enter_i;
  end

  for (genvar g = 0; g < NUM_P; g++) begin : g_pulse
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pulse_o[g] <= 1'b0;
      else         pulse_o[g] <= ev[g];
    end
  end
endmodule

// File: rtl/disp_timing.sv
module disp_timing
  import disp_timing_pkg::*;
#(
  parameter int ACTIVE_TICKS = 3072,
  parameter int BLANK_TICKS  = 1188,
  parameter int LINES        = 263,
  parameter int VIS_LINES    = 192,
  localparam int LINE_W      = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [15:0]       wr_data_i,
  output logic [15:0]       stat_o,
  output logic [LINE_W-1:0] line_o,
  output logic              irq_vblank_o,
  output logic              irq_hblank_o,
  output logic              irq_match_o,
  output logic              hblank_dma_o,
  output logic              vblank_dma_o
);
  logic              hb_start, line_end;
  logic [LINE_W-1:0] line_nxt;
  logic              vb_enter, lm_rise, en_vb, en_hb, en_lm;
  logic [NUM_P-1:0]  pulse;

  dt_hcount #(.ACTIVE_TICKS(ACTIVE_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_h (
    .clk_i, .rst_ni, .hb_start_o(hb_start), .line_end_o(line_end)
  );

  dt_vcount #(.LINES(LINES), .LINE_W(LINE_W)) u_v (
    .clk_i, .rst_ni, .adv_i(line_end), .line_o(line_o), .line_nxt_o(line_nxt)
  );

  dt_status #(.VIS_LINES(VIS_LINES), .LINE_W(LINE_W)) u_st (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .hb_start_i(hb_start), .line_end_i(line_end), .line_nxt_i(line_nxt),
    .stat_o(stat_o), .vb_enter_o(vb_enter), .lm_rise_o(lm_rise),
    .en_vb_o(en_vb), .en_hb_o(en_hb), .en_lm_o(en_lm)
  );

  dt_irq u_irq (
    .clk_i, .rst_ni, .hb_start_i(hb_start), .vb_enter_i(vb_enter),
    .lm_rise_i(lm_rise), .line_vis_i(line_o < LINE_W'(VIS_LINES)),
    .en_vb_i(en_vb), .en_hb_i(en_hb), .en_lm_i(en_lm), .pulse_o(pulse)
  );

  assign irq_vblank_o = pulse[P_VIRQ];
  assign irq_hblank_o = pulse[P_HIRQ];
  assign irq_match_o  = pulse[P_MIRQ];
  assign hblank_dma_o = pulse[P_HDMA];
  assign vblank_dma_o = pulse[P_VDMA];
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
  parameter int LINES     = 263,
  parameter int VIS_LINES = 192,
  parameter int LINE_W    = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       stat_o,
  input logic [LINE_W-1:0] line_o,
  input logic              irq_vblank_o,
  input logic              irq_hblank_o,
  input logic              irq_match_o,
  input logic              hblank_dma_o,
  input logic              vblank_dma_o
);
  p_line_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |->
      ((32'(line_o) == 32'($past(line_o)) + 1) ||
       (line_o == '0 && 32'($past(line_o)) == LINES - 1)));

  p_hb_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> !stat_o[1]);

  p_vb_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] == (32'(line_o) >= VIS_LINES));

  p_match_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o == $past(line_o)) |-> $stable(stat_o[2]));

  p_mirq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_match_o |-> (stat_o[2] && !$past(stat_o[2]) && $past(stat_o[5])));

  p_hdma_vis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hblank_dma_o |-> (stat_o[1] && !$past(stat_o[1]) && 32'(line_o) < VIS_LINES));

  p_vdma_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_dma_o |-> (32'(line_o) == VIS_LINES && $rose(stat_o[0])));

  p_hirq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_hblank_o |-> ($rose(stat_o[1]) && $past(stat_o[4])));

  p_virq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vblank_o |-> ($rose(stat_o[0]) && $past(stat_o[3])));

  p_pulse_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hblank_o || irq_vblank_o) |=> !(irq_hblank_o || irq_vblank_o));

  p_bit6_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_o[6]);
endmodule

bind disp_timing dt_checker #(
  .LINES(LINES), .VIS_LINES(VIS_LINES), .LINE_W(LINE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stat_o(stat_o), .line_o(line_o),
  .irq_vblank_o(irq_vblank_o), .irq_hblank_o(irq_hblank_o),
  .irq_match_o(irq_match_o), .hblank_dma_o(hblank_dma_o),
  .vblank_dma_o(vblank_dma_o)
);

// File: tb/tb_disp_timing.sv
module tb_disp_timing;
  localparam int ACT  = 6;
  localparam int BLK  = 4;
  localparam int TOT  = ACT + BLK;
  localparam int LN   = 12;
  localparam int VIS  = 8;
  localparam int LW   = $clog2(LN);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [15:0]   wr_data_i = '0;
  logic [15:0]   stat_o;
  logic [LW-1:0] line_o;
  logic irq_vblank_o, irq_hblank_o, irq_match_o, hblank_dma_o, vblank_dma_o;

  int n_chk = 0;
  int n_bad = 0;

  disp_timing #(.ACTIVE_TICKS(ACT), .BLANK_TICKS(BLK), .LINES(LN), .VIS_LINES(VIS)) dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .stat_o, .line_o,
    .irq_vblank_o, .irq_hblank_o, .irq_match_o, .hblank_dma_o, .vblank_dma_o
  );

  always #2 clk_i = ~clk_i;

  // reference model built from the requirements
  int m_h, m_line;
  bit m_hb, m_vb, m_lm;
  bit [15:0] m_ctrl;
  bit m_virq, m_hirq, m_mirq, m_hdma, m_vdma;

  function automatic bit [15:0] m_stat();
    return m_ctrl | {13'd0, m_lm, m_hb, m_vb};
  endfunction

  function automatic int next_line(int l);
    return (l == LN - 1) ? 0 : l + 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_h = 0; m_line = 0; m_hb = 0; m_vb = 0; m_lm = 0; m_ctrl = '0;
      m_virq = 0; m_hirq = 0; m_mirq = 0; m_hdma = 0; m_vdma = 0;
    end else begin
      m_virq = 0; m_hirq = 0; m_mirq = 0; m_hdma = 0; m_vdma = 0;
      if (m_h == ACT - 1) begin
        m_hb = 1; m_hdma = (m_line < VIS); m_hirq = m_ctrl[4];
      end
      if (m_h == TOT - 1) begin
        int nl;
        bit nm;
        nl = next_line(m_line);
        m_hb = 0;
        if (nl == VIS) begin m_vb = 1; m_vdma = 1; m_virq = m_ctrl[3]; end
        else if (nl == 0) m_vb = 0;
        nm = (nl == int'({m_ctrl[7], m_ctrl[15:8]}));
        m_mirq = nm && !m_lm && m_ctrl[5];
        m_lm = nm;
        m_line = nl;
        m_h = 0;
      end else m_h = m_h + 1;
      if (wr_en_i) m_ctrl = wr_data_i & 16'hFFB8;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "line", int'(line_o), m_line);
    chk("R3", "hblank flag", int'(stat_o[1]), int'(m_hb));
    chk("R4", "vblank flag", int'(stat_o[0]), int'(m_vb));
    chk("R5", "match flag", int'(stat_o[2]), int'(m_lm));
    chk("R9", "status word", int'(stat_o), int'(m_stat()));
    chk("R6", "match irq", int'(irq_match_o), int'(m_mirq));
    chk("R7", "hblank dma", int'(hblank_dma_o), int'(m_hdma));
    chk("R7", "vblank dma", int'(vblank_dma_o), int'(m_vdma));
    chk("R8", "vblank irq", int'(irq_vblank_o), int'(m_virq));
    chk("R8", "hblank irq", int'(irq_hblank_o), int'(m_hirq));
  endtask

  task automatic check_reset_state();
    chk("R1", "status", int'(stat_o), 0);
    chk("R1", "line", int'(line_o), 0);
    chk("R1", "pulses", int'({irq_vblank_o, irq_hblank_o, irq_match_o,
                              hblank_dma_o, vblank_dma_o}), 0);
  endtask

  function automatic bit [15:0] pick_word(int mode);
    bit [15:0] w;
    w = 16'($urandom);
    if (mode == 0) begin
      w[15:8] = 8'($urandom_range(0, LN - 1));
      w[7]    = 1'b0;
    end
    return w;
  endfunction

  task automatic cycle(input bit we, input bit [15:0] d);
    wr_en_i = we; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      bit we;
      we = ($urandom_range(0, 15) == 0);
      cycle(we, pick_word(($urandom_range(0, 3) == 0) ? 1 : 0));
    end
  endtask

  bit done = 0;

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check_reset_state();            // R1 during reset
    rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check_reset_state();            // R1 first cycle after reset
    // R6/R8: enable all, match line 3
    cycle(1'b1, 16'h0338);
    run_random(0);
    for (int i = 0; i < 2 * LN * TOT; i++) cycle(1'b0, 16'h0);
    // R5: bit 8 set blocks match on low bits
    cycle(1'b1, 16'h05B8);
    for (int i = 0; i < LN * TOT; i++) cycle(1'b0, 16'h0);
    // R9: write flag bits and bit 6
    cycle(1'b1, 16'h0047);
    // R6: move compare to next line right after a match
    cycle(1'b1, 16'h0138);
    while (line_o != LW'(1)) cycle(1'b0, 16'h0);
    cycle(1'b1, 16'h0238);
    for (int i = 0; i < 2 * TOT; i++) cycle(1'b0, 16'h0);
    run_random(3000);
    // mid-run reset
    rst_ni = 1'b0;
    #1;
    check_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check_reset_state();
    run_random(1500);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule